// File: doc/BRIEF.md
# Snooping Write-Back Cache Line Coherence Controller

This block keeps the four-state coherence status (Modified, Exclusive, Shared, Invalid) for every line of one private write-back cache that sits on a shared snooping bus. It holds a small direct-mapped array of line states, indexed by the low address bits. Tags, data storage and replacement are handled elsewhere. The controller serves read and write requests from its own processor. It reports a hit or a miss for each one and, on a miss, places a bus request that is held until the bus grants it.

The controller also watches every transaction that other caches place on the bus. For each one it returns a combinational hit indication, which the surrounding logic ORs onto the bus shared line. When the line is dirty it returns a flush indication that tells the data path to write the block back and supply it. It then downgrades or invalidates the line. A plain drop input lets the surrounding cache discard clean shared copies. A lookup port returns the state of any line for replacement decisions.

Processor requests use a valid/ready handshake. `cpu_req_ready` is low while a bus transaction is outstanding and in any cycle in which a snoop or a drop is presented. A request is accepted on a clock edge where valid and ready are both high. The response is a one-cycle pulse with no back-pressure. The bus request is a valid/grant pair: valid stays high with a stable address until `bus_gnt` is sampled high, and the transaction completes in that cycle. The bus arbiter never grants this cache in a cycle where it presents a snoop for the same line.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line reads as Invalid on the lookup port (encoding I=0, S=1, E=2, M=3), no bus request is raised, and the processor port is ready.
- R2: A read to an Invalid line raises a bus read (command code 0). On grant the line becomes Exclusive if `bus_shared` is low and Shared if it is high. One cycle after the grant a response pulse appears with hit low.
- R3: A read to a line in S, E or M produces a response pulse with hit high one cycle after acceptance. It raises no bus request and leaves the state unchanged.
- R4: A write to a line in E or M is a hit that raises no bus request and leaves the line Modified.
- R5: A write to a Shared line raises an upgrade (code 2). A write to an Invalid line raises a read-exclusive (code 1). Either one leaves the line Modified after the grant, with a response pulse with hit low.
- R6: While a bus request waits for grant, it stays valid with a stable address and the processor port is not ready. If a snoop or drop invalidates the line while an upgrade is waiting, the command changes to read-exclusive.
- R7: A snooped bus read (snoop code 0) on a Modified line asserts flush and moves the line to Shared. On an Exclusive line it moves the line to Shared without flush. A Shared line stays Shared. Snoop hit is high whenever the addressed line is valid.
- R8: A snooped read-exclusive (code 1) or upgrade (code 2) invalidates a valid line. Flush is asserted only if the line was Modified.
- R9: A snooped write-back (code 3) or cache-to-cache supply (code 4) changes no state and never asserts flush. A snoop to an Invalid line asserts neither flush nor snoop hit.
- R10: A drop turns a Shared line Invalid and has no effect on lines in E or M.
- R11: The processor port is not ready in any cycle in which a snoop or a drop is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Processor request accepted when high |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Request address; low bits select the line |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_hit | output | 1 | Response was a hit |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | 0 read, 1 read-exclusive, 2 upgrade |
| bus_req_addr | output | ADDR_W | Address of the bus transaction |
| bus_gnt | input | 1 | Grant; transaction completes in this cycle |
| bus_shared | input | 1 | Another cache holds the block (sampled with grant) |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 3 | 0 read, 1 read-exclusive, 2 upgrade, 3 write-back, 4 supply |
| snp_addr | input | ADDR_W | Snooped address |
| snp_hit | output | 1 | Snooped line is valid here |
| snp_flush | output | 1 | This cache must write back and supply the block |
| drop_valid | input | 1 | Discard request for a clean shared line |
| drop_addr | input | ADDR_W | Address to discard |
| look_addr | input | ADDR_W | Lookup address |
| look_state | output | 2 | State of the looked-up line |

## Verification
The bench first checks the silent upgrade from Exclusive to Modified. A design that sent an upgrade there would show a bus request where none is allowed. Next it checks the race in which another cache's upgrade invalidates a Shared line while this cache's own upgrade waits for grant. A design that froze the command would still send an upgrade for a line it no longer holds, and would end Modified with stale data. Further checks cover the split between a flush from Modified and a silent downgrade from Exclusive, and the `bus_shared` choice between Exclusive and Shared on a fill. A wrong design there would supply data twice or leave two caches each believing they hold an exclusive copy. Finally, write-back and supply snoops and drops of dirty lines must leave state alone. A design that acted on them would lose dirty data.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_E = 2'd2,
    LS_M = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    BR_RD   = 2'd0,
    BR_RDX  = 2'd1,
    BR_UPGR = 2'd2
  } bus_cmd_t;

  typedef enum logic [2:0] {
    SN_RD     = 3'd0,
    SN_RDX    = 3'd1,
    SN_UPGR   = 3'd2,
    SN_WBACK  = 3'd3,
    SN_SUPPLY = 3'd4
  } snp_cmd_t;
endpackage

// File: rtl/coh_state_array.sv
module coh_state_array #(
  parameter int LINES = 16,
  parameter int NRD   = 5,
  parameter int NWR   = 3,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NRD-1:0][IDX_W-1:0]  rd_idx,
  output logic [NRD-1:0][1:0]        rd_st,
  input  logic [NWR-1:0]             wr_en,
  input  logic [NWR-1:0][IDX_W-1:0]  wr_idx,
  input  logic [NWR-1:0][1:0]        wr_st
);
  logic [LINES-1:0][1:0] st_q;

  // one register per line; later write ports take priority
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g] <= coh_pkg::LS_I;
      end else begin
        for (int w = 0; w < NWR; w++) begin
          if (wr_en[w] && wr_idx[w] == IDX_W'(g)) st_q[g] <= wr_st[w];
        end
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_st[p] = st_q[rd_idx[p]];
  end
endmodule

// File: rtl/coh_snoop_xlate.sv
module coh_snoop_xlate
  import coh_pkg::*;
(
  input  logic       snp_valid,
  input  logic [2:0] snp_cmd,
  input  logic [1:0] cur_st,
  output logic [1:0] nxt_st,
  output logic       chg,
  output logic       hit,
  output logic       flush
);
  line_st_t cur;
  assign cur = line_st_t'(cur_st);

  always_comb begin
    hit    = snp_valid && (cur != LS_I);
    nxt_st = cur_st;
    flush  = 1'b0;
    if (hit) begin
      case (snp_cmd)
        SN_RD: begin
          flush  = (cur == LS_M);
          nxt_st = LS_S;
        end
        SN_RDX, SN_UPGR: begin
          flush  = (cur == LS_M);
          nxt_st = LS_I;
        end
        default: nxt_st = cur_st;
      endcase
    end
    chg = hit && (nxt_st != cur_st);
  end
endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_rsp_valid,
  output logic              cpu_rsp_hit,
  input  logic              block,
  input  logic [1:0]        cur_st,
  input  logic [1:0]        pend_st,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] pend_addr,
  input  logic              bus_gnt,
  input  logic              bus_shared,
  output logic              upd_en,
  output logic [ADDR_W-1:0] upd_addr,
  output logic [1:0]        upd_st
);
  typedef enum logic {PH_IDLE, PH_WAIT} phase_t;

  phase_t ph_q;
  logic   pw_q;
  logic   accept, is_hit;
  line_st_t cur, pend;

  assign cur  = line_st_t'(cur_st);
  assign pend = line_st_t'(pend_st);

  assign cpu_req_ready = (ph_q == PH_IDLE) && !block;
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign is_hit        = cpu_req_write ? (cur == LS_E || cur == LS_M) : (cur != LS_I);
  assign bus_req_valid = (ph_q == PH_WAIT);

  // command follows the live state so a lost shared copy turns into RDX
  always_comb begin
    if (!pw_q)              bus_req_cmd = BR_RD;
    else if (pend == LS_S)  bus_req_cmd = BR_UPGR;
    else                    bus_req_cmd = BR_RDX;
  end

  always_comb begin
    upd_en   = 1'b0;
    upd_addr = cpu_req_addr;
    upd_st   = LS_M;
    if (bus_req_valid && bus_gnt) begin
      upd_en   = 1'b1;
      upd_addr = pend_addr;
      upd_st   = pw_q ? LS_M : (bus_shared ? LS_S : LS_E);
    end else if (accept && is_hit && cpu_req_write && cur == LS_E) begin
      upd_en = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q          <= PH_IDLE;
      pw_q          <= 1'b0;
      pend_addr     <= '0;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_hit   <= 1'b0;
    end else begin
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_hit   <= 1'b0;
      if (ph_q == PH_IDLE) begin
        if (accept && is_hit) begin
          cpu_rsp_valid <= 1'b1;
          cpu_rsp_hit   <= 1'b1;
        end else if (accept) begin
          ph_q      <= PH_WAIT;
          pw_q      <= cpu_req_write;
          pend_addr <= cpu_req_addr;
        end
      end else if (bus_gnt) begin
        ph_q          <= PH_IDLE;
        cpu_rsp_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_rsp_valid,
  output logic              cpu_rsp_hit,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_gnt,
  input  logic              bus_shared,
  input  logic              snp_valid,
  input  logic [2:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_hit,
  output logic              snp_flush,
  input  logic              drop_valid,
  input  logic [ADDR_W-1:0] drop_addr,
  input  logic [ADDR_W-1:0] look_addr,
  output logic [1:0]        look_state
);
  localparam int IDX_W = $clog2(LINES);
  localparam int NRD   = 5;
  localparam int NWR   = 3;
  localparam int RP_CPU = 0, RP_PEND = 1, RP_SNP = 2, RP_DROP = 3, RP_LOOK = 4;
  localparam int WP_DROP = 0, WP_SNP = 1, WP_FSM = 2;

  logic [NRD-1:0][IDX_W-1:0] rd_idx;
  logic [NRD-1:0][1:0]       rd_st;
  logic [NWR-1:0]            wr_en;
  logic [NWR-1:0][IDX_W-1:0] wr_idx;
  logic [NWR-1:0][1:0]       wr_st;

  logic [1:0]        snp_nxt;
  logic              snp_chg;
  logic              upd_en;
  logic [ADDR_W-1:0] upd_addr;
  logic [1:0]        upd_st;

  assign rd_idx[RP_CPU]  = cpu_req_addr[IDX_W-1:0];
  assign rd_idx[RP_PEND] = bus_req_addr[IDX_W-1:0];
  assign rd_idx[RP_SNP]  = snp_addr[IDX_W-1:0];
  assign rd_idx[RP_DROP] = drop_addr[IDX_W-1:0];
  assign rd_idx[RP_LOOK] = look_addr[IDX_W-1:0];
  assign look_state      = rd_st[RP_LOOK];

  coh_state_array #(.LINES(LINES), .NRD(NRD), .NWR(NWR)) u_arr (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (rd_idx),
    .rd_st  (rd_st),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_st  (wr_st)
  );

  coh_snoop_xlate u_snp (
    .snp_valid (snp_valid),
    .snp_cmd   (snp_cmd),
    .cur_st    (rd_st[RP_SNP]),
    .nxt_st    (snp_nxt),
    .chg       (snp_chg),
    .hit       (snp_hit),
    .flush     (snp_flush)
  );

  coh_req_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_req_write (cpu_req_write),
    .cpu_req_addr  (cpu_req_addr),
    .cpu_rsp_valid (cpu_rsp_valid),
    .cpu_rsp_hit   (cpu_rsp_hit),
    .block         (snp_valid || drop_valid),
    .cur_st        (rd_st[RP_CPU]),
    .pend_st       (rd_st[RP_PEND]),
    .bus_req_valid (bus_req_valid),
    .bus_req_cmd   (bus_req_cmd),
    .pend_addr     (bus_req_addr),
    .bus_gnt       (bus_gnt),
    .bus_shared    (bus_shared),
    .upd_en        (upd_en),
    .upd_addr      (upd_addr),
    .upd_st        (upd_st)
  );

  // drop only affects clean shared copies
  assign wr_en[WP_DROP]  = drop_valid && (rd_st[RP_DROP] == LS_S);
  assign wr_idx[WP_DROP] = drop_addr[IDX_W-1:0];
  assign wr_st[WP_DROP]  = LS_I;

  assign wr_en[WP_SNP]   = snp_chg;
  assign wr_idx[WP_SNP]  = snp_addr[IDX_W-1:0];
  assign wr_st[WP_SNP]   = snp_nxt;

  assign wr_en[WP_FSM]   = upd_en;
  assign wr_idx[WP_FSM]  = upd_addr[IDX_W-1:0];
  assign wr_st[WP_FSM]   = upd_st;
endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              cpu_rsp_hit,
  input logic              bus_req_valid,
  input logic [ADDR_W-1:0] bus_req_addr,
  input logic              bus_gnt,
  input logic              snp_valid,
  input logic [2:0]        snp_cmd,
  input logic              snp_hit,
  input logic              snp_flush,
  input logic              drop_valid
);
  p_hold_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_gnt |=> bus_req_valid && $stable(bus_req_addr));

  p_stall_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> !cpu_req_ready);

  p_grant_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_gnt |=> cpu_rsp_valid && !cpu_rsp_hit);

  p_hit_no_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && cpu_rsp_hit |-> !bus_req_valid);

  p_flush_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> snp_hit);

  p_quiet_snoop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_cmd >= 3'd3 |-> !snp_flush);

  p_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid || drop_valid) |-> !cpu_req_ready);
endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req_ready (cpu_req_ready),
  .cpu_rsp_valid (cpu_rsp_valid),
  .cpu_rsp_hit   (cpu_rsp_hit),
  .bus_req_valid (bus_req_valid),
  .bus_req_addr  (bus_req_addr),
  .bus_gnt       (bus_gnt),
  .snp_valid     (snp_valid),
  .snp_cmd       (snp_cmd),
  .snp_hit       (snp_hit),
  .snp_flush     (snp_flush),
  .drop_valid    (drop_valid)
);

// File: tb/coh_line_ctrl_test.sv
module coh_line_ctrl_test;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic cpu_req_ready, cpu_rsp_valid, cpu_rsp_hit;
  logic bus_req_valid;
  logic [1:0] bus_req_cmd;
  logic [AW-1:0] bus_req_addr;
  logic bus_gnt = 1'b0, bus_shared = 1'b0;
  logic snp_valid = 1'b0;
  logic [2:0] snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic snp_hit, snp_flush;
  logic drop_valid = 1'b0;
  logic [AW-1:0] drop_addr = '0, look_addr = '0;
  logic [1:0] look_state;

  int checks = 0;
  int errors = 0;
  bit exp_q[$];

  always #2 clk = ~clk;

  coh_line_ctrl #(.ADDR_W(AW), .LINES(16)) uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_hit(cpu_rsp_hit),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd),
    .bus_req_addr(bus_req_addr), .bus_gnt(bus_gnt), .bus_shared(bus_shared),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_hit(snp_hit), .snp_flush(snp_flush),
    .drop_valid(drop_valid), .drop_addr(drop_addr),
    .look_addr(look_addr), .look_state(look_state)
  );

  task automatic chk_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected hit flag per response pulse
  always @(negedge clk) begin
    if (rst_n && cpu_rsp_valid) begin
      if (exp_q.size() == 0) chk_eq("R3", "unexpected response", 1, 0);
      else chk_eq("R2/R3 response", "hit flag", int'(cpu_rsp_hit), int'(exp_q.pop_front()));
    end
  end

  task automatic look(logic [AW-1:0] a, int exp, string req);
    look_addr = a;
    #1;
    chk_eq(req, "line state", int'(look_state), exp);
  endtask

  task automatic cpu_op(bit wr, logic [AW-1:0] a, bit exp_hit, int exp_cmd,
                        bit sh, bit hold, string req);
    @(negedge clk);
    exp_q.push_back(exp_hit);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    if (exp_hit) begin
      chk_eq(req, "no bus request on hit", int'(bus_req_valid), 0);
    end else begin
      chk_eq(req, "bus request raised", int'(bus_req_valid), 1);
      chk_eq(req, "bus command", int'(bus_req_cmd), exp_cmd);
      chk_eq(req, "bus address", int'(bus_req_addr), int'(a));
      if (hold) begin
        @(negedge clk);
        chk_eq("R6", "request held without grant", int'(bus_req_valid), 1);
        chk_eq("R6", "processor stalled", int'(cpu_req_ready), 0);
      end
      bus_gnt = 1'b1; bus_shared = sh;
      @(negedge clk);
      bus_gnt = 1'b0; bus_shared = 1'b0;
      chk_eq(req, "request cleared after grant", int'(bus_req_valid), 0);
    end
  endtask

  task automatic snoop(int cmd, logic [AW-1:0] a, int exp_flush, int exp_hit, string req);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 3'(cmd); snp_addr = a;
    #1;
    chk_eq(req, "snoop flush", int'(snp_flush), exp_flush);
    chk_eq(req, "snoop hit", int'(snp_hit), exp_hit);
    chk_eq("R11", "ready low during snoop", int'(cpu_req_ready), 0);
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic drop(logic [AW-1:0] a);
    @(negedge clk);
    drop_valid = 1'b1; drop_addr = a;
    #1;
    chk_eq("R11", "ready low during drop", int'(cpu_req_ready), 0);
    @(negedge clk);
    drop_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_eq("R1", "ready after reset", int'(cpu_req_ready), 1);
    chk_eq("R1", "no bus request after reset", int'(bus_req_valid), 0);
    look(8'h03, 0, "R1");
    look(8'h0f, 0, "R1");

    // R2 read miss, not shared -> E
    cpu_op(1'b0, 8'h03, 1'b0, 0, 1'b0, 1'b1, "R2");
    look(8'h03, 2, "R2");
    // R3 read hit in E
    cpu_op(1'b0, 8'h03, 1'b1, 0, 1'b0, 1'b0, "R3");
    look(8'h03, 2, "R3");
    // R4 silent E -> M, then write to M stays M
    cpu_op(1'b1, 8'h03, 1'b1, 0, 1'b0, 1'b0, "R4");
    look(8'h03, 3, "R4");
    cpu_op(1'b1, 8'h03, 1'b1, 0, 1'b0, 1'b0, "R4");
    look(8'h03, 3, "R4");
    // R3 read hit in M
    cpu_op(1'b0, 8'h03, 1'b1, 0, 1'b0, 1'b0, "R3");
    look(8'h03, 3, "R3");
    // R7 snooped read on M flushes -> S
    snoop(0, 8'h03, 1, 1, "R7");
    look(8'h03, 1, "R7");
    snoop(0, 8'h03, 0, 1, "R7");
    look(8'h03, 1, "R7");
    // R5 write to S -> upgrade -> M
    cpu_op(1'b1, 8'h03, 1'b0, 2, 1'b0, 1'b0, "R5");
    look(8'h03, 3, "R5");
    // R8 read-exclusive on M flushes and invalidates
    snoop(1, 8'h03, 1, 1, "R8");
    look(8'h03, 0, "R8");

    // R2 read miss with shared -> S
    cpu_op(1'b0, 8'h05, 1'b0, 0, 1'b1, 1'b0, "R2");
    look(8'h05, 1, "R2");
    // R9 write-back and supply snoops change nothing
    snoop(3, 8'h05, 0, 1, "R9");
    snoop(4, 8'h05, 0, 1, "R9");
    look(8'h05, 1, "R9");
    // R10 drop of S
    drop(8'h05);
    look(8'h05, 0, "R10");

    // R9 snoop to Invalid line
    snoop(0, 8'h07, 0, 0, "R9");
    look(8'h07, 0, "R9");
    // R5 write miss -> read-exclusive -> M
    cpu_op(1'b1, 8'h07, 1'b0, 1, 1'b0, 1'b1, "R5");
    look(8'h07, 3, "R5");
    // R10 drop ignored on M
    drop(8'h07);
    look(8'h07, 3, "R10");

    // R7 snooped read on E -> S without flush
    cpu_op(1'b0, 8'h08, 1'b0, 0, 1'b0, 1'b0, "R2");
    look(8'h08, 2, "R2");
    snoop(0, 8'h08, 0, 1, "R7");
    look(8'h08, 1, "R7");
    // R8 upgrade snoop invalidates S without flush
    snoop(2, 8'h08, 0, 1, "R8");
    look(8'h08, 0, "R8");

    // R6 pending upgrade overtaken by another cache's upgrade
    cpu_op(1'b0, 8'h09, 1'b0, 0, 1'b1, 1'b0, "R2");
    look(8'h09, 1, "R2");
    @(negedge clk);
    exp_q.push_back(1'b0);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = 8'h09;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    chk_eq("R6", "upgrade raised", int'(bus_req_cmd), 2);
    snp_valid = 1'b1; snp_cmd = 3'd2; snp_addr = 8'h09;
    #1;
    chk_eq("R8", "snoop hit while pending", int'(snp_hit), 1);
    @(negedge clk);
    snp_valid = 1'b0;
    chk_eq("R6", "still pending", int'(bus_req_valid), 1);
    chk_eq("R6", "command turned read-exclusive", int'(bus_req_cmd), 1);
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    look(8'h09, 3, "R5");

    repeat (3) @(negedge clk);
    chk_eq("R2", "all responses seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule